// File: doc/BRIEF.md
# Prescaled Capture/Compare Timer

This block is a 16-bit general-purpose timer. Its count is advanced by a tick chosen from four sources: none (stopped), the system clock, the system clock divided by 16, or rising edges of an external input. That source then passes through an 8-bit prescaler. The count is compared against a programmable compare value. On a match the counter either restarts from zero or keeps running, as a mode bit selects. The match can also drive an output pin, either as a one-tick low pulse or as a toggle.

A capture input is synchronized and edge-detected. On the selected transition it latches the current count into a capture register. Match and capture events set sticky flags, which are cleared by writing ones. An interrupt line is raised from those flags through their enables.

Software reaches the block through a small register port. A write takes effect on the clock edge where the strobe is high. Reads are combinational from the address.

Top module: `gp_timer`

## Requirements
- R1: After synchronous reset, the mode, compare, capture, count and event registers read 0, `tmr_out` is high and `irq` is low.
- R2: The mode register (address 0) places its fields as follows. Bits 15:8 hold the prescale value, bits 7:6 the capture edge, bit 5 the output style, bit 4 the compare interrupt enable, bit 3 restart-on-match, bits 2:1 the tick source and bit 0 run. While run is 0, the counter, prescaler and divider are held at 0 and `tmr_out` is held high.
- R3: Tick source encoding: 00 stops counting, 01 uses every system clock, 10 uses one clock in 16, and 11 uses rising edges of `ext_clk` after a two-flop synchronizer.
- R4: A prescale value N lets the count advance once every N+1 source ticks.
- R5: A match occurs when a prescaled tick arrives while the count equals the compare value (address 1). With restart set, the count then becomes 0. With restart clear, it keeps incrementing and wraps from 0xFFFF to 0.
- R6: With output style 0, a match drives `tmr_out` low until the next non-matching prescaled tick, and it idles high. With output style 1, each match inverts `tmr_out`.
- R7: `cap_in` passes through a two-flop synchronizer. Capture edge encoding: 00 off, 01 rising, 10 falling, 11 both. On a selected edge, the current count is copied into the capture register (address 2).
- R8: Event register (address 4): bit 0 is set by a capture and bit 1 by a match. Each bit stays set until a 1 is written to it. A new event in the same cycle as a clear wins.
- R9: `irq` is high exactly when (event bit 1 and compare interrupt enable) or (event bit 0 and capture edge not 00).
- R10: The count reads at address 3. Writes to addresses 2 and 3 have no effect, and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| ext_clk | input | 1 | External count input, asynchronous |
| cap_in | input | 1 | Capture input, asynchronous |
| tmr_out | output | 1 | Match output pin |
| irq | output | 1 | Interrupt request |

## Verification
The counting path is exercised from each tick source in turn: the full clock, the divide-by-16 path with prescaling, external edges arriving at irregular spacing, and the stopped source. Comparing the count every cycle tells a wrong divide ratio apart from a wrong synchronizer delay. A long free-running pass in toggle mode crosses the 16-bit wrap, and a short restart pass in pulse mode shows the count and pulse timing around the compare value. Capture is driven with irregular `cap_in` toggles under every edge setting, including off, so that rising, falling and both-edge selection each produce a distinct capture history.

// File: rtl/gp_timer_pkg.sv
package gp_timer_pkg;

    localparam int BUS_W  = 16;
    localparam int PS_W   = 8;
    localparam int DIV_W  = 4;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
    localparam logic [ADDR_W-1:0] A_CMP  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CAP  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_EVT  = 3'd4;

    localparam int EV_CAP = 0;
    localparam int EV_CMP = 1;
    localparam int EV_W   = 2;

    typedef enum logic [1:0] {
        SRC_STOP = 2'b00,
        SRC_SYS  = 2'b01,
        SRC_DIV  = 2'b10,
        SRC_EXT  = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } cap_edge_e;

    // Field order is the software-visible bit layout, MSB first.
    typedef struct packed {
        logic [PS_W-1:0] ps;
        cap_edge_e       cap_sel;
        logic            toggle;
        logic            ref_ie;
        logic            restart;
        src_sel_e        src;
        logic            run;
    } mode_t;

    function automatic logic cap_fire(cap_edge_e sel, logic lvl, logic prev);
        logic rise;
        logic fall;
        rise = lvl & ~prev;
        fall = ~lvl & prev;
        case (sel)
            EDGE_RISE: return rise;
            EDGE_FALL: return fall;
            EDGE_BOTH: return rise | fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gp_timer_sync.sv
module gp_timer_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic lvl,
    output logic prev
);
    // STAGES synchronizer flops followed by one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= {sh_q[STAGES-1:0], d};
    end

    assign lvl  = sh_q[STAGES-1];
    assign prev = sh_q[STAGES];
endmodule

// File: rtl/gp_timer_tickgen.sv
module gp_timer_tickgen
    import gp_timer_pkg::*;
#(
    parameter int PRE_W = PS_W,
    parameter int DV_W  = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  src_sel_e         src,
    input  logic [PRE_W-1:0] ps,
    input  logic             ext_rise,
    output logic             tick
);
    logic [DV_W-1:0]  div_q;
    logic [PRE_W-1:0] pre_q;
    logic             src_tick;

    always_comb begin
        case (src)
            SRC_SYS: src_tick = run;
            SRC_DIV: src_tick = run & (div_q == '1);
            SRC_EXT: src_tick = run & ext_rise;
            default: src_tick = 1'b0;
        endcase
    end

    assign tick = src_tick && (pre_q == ps);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
            pre_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
            if (src_tick) pre_q <= (pre_q == ps) ? '0 : pre_q + 1'b1;
        end
    end

    AST_STOP_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_STOP) |-> !tick); // R3
    AST_PRE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (src_tick && pre_q == ps) |=> (pre_q == '0)); // R4
    AST_HALT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pre_q == '0 && div_q == '0)); // R2
endmodule

// File: rtl/gp_timer_counter.sv
module gp_timer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             restart,
    input  logic             toggle,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match,
    output logic             out_q
);
    assign match = tick && (cnt_q == cmp_val);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            out_q <= 1'b1;
        end else if (match) begin
            cnt_q <= restart ? '0 : cnt_q + 1'b1;
            out_q <= toggle ? ~out_q : 1'b0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
            if (!toggle) out_q <= 1'b1;
        end
    end

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (rst)
        (run && match && restart) |=> (cnt_q == '0)); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0 && out_q)); // R2
    AST_PULSE_LOW: assert property (@(posedge clk) disable iff (rst)
        (run && match && !toggle) |=> !out_q); // R6
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        (run && match && toggle) |=> (out_q != $past(out_q))); // R6
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/gp_timer_capture.sv
module gp_timer_capture
    import gp_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cap_edge_e        cap_sel,
    input  logic             lvl,
    input  logic             prev,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap_q,
    output logic             hit
);
    assign hit = cap_fire(cap_sel, lvl, prev);

    always_ff @(posedge clk) begin
        if (rst)      cap_q <= '0;
        else if (hit) cap_q <= cnt;
    end

    AST_CAP_OFF: assert property (@(posedge clk) disable iff (rst)
        (cap_sel == EDGE_OFF) |=> $stable(cap_q)); // R7
    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        hit |=> (cap_q == $past(cnt))); // R7
endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gp_timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              ext_clk,
    input  logic              cap_in,
    output logic              tmr_out,
    output logic              irq
);
    mode_t            mode_q;
    logic [CNT_W-1:0] cmp_q;
    logic [EV_W-1:0]  ev_q;
    logic [EV_W-1:0]  ev_set;
    logic [EV_W-1:0]  ev_clr;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cap_q;
    logic             ext_lvl, ext_prev;
    logic             cap_lvl, cap_prev;
    logic             tick, match, cap_hit, out_q;

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            cmp_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MODE) mode_q <= mode_t'(bus_wdata);
            if (bus_addr == A_CMP)  cmp_q  <= CNT_W'(bus_wdata);
        end
    end

    gp_timer_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst(rst), .d(ext_clk), .lvl(ext_lvl), .prev(ext_prev)
    );

    gp_timer_sync #(.STAGES(SYNC_STAGES)) u_cap_sync (
        .clk(clk), .rst(rst), .d(cap_in), .lvl(cap_lvl), .prev(cap_prev)
    );

    gp_timer_tickgen #(.PRE_W(PS_W), .DV_W(DIV_W)) u_tickgen (
        .clk(clk), .rst(rst), .run(mode_q.run), .src(mode_q.src),
        .ps(mode_q.ps), .ext_rise(ext_lvl & ~ext_prev), .tick(tick)
    );

    gp_timer_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst(rst), .run(mode_q.run), .tick(tick),
        .restart(mode_q.restart), .toggle(mode_q.toggle), .cmp_val(cmp_q),
        .cnt_q(cnt_q), .match(match), .out_q(out_q)
    );

    gp_timer_capture #(.CNT_W(CNT_W)) u_capture (
        .clk(clk), .rst(rst), .cap_sel(mode_q.cap_sel), .lvl(cap_lvl),
        .prev(cap_prev), .cnt(cnt_q), .cap_q(cap_q), .hit(cap_hit)
    );

    // sticky event flags: set wins over a same-cycle write-one-to-clear
    always_comb begin
        ev_set         = '0;
        ev_set[EV_CAP] = cap_hit;
        ev_set[EV_CMP] = match;
        ev_clr         = (bus_wr && bus_addr == A_EVT) ? bus_wdata[EV_W-1:0] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) ev_q <= '0;
        else     ev_q <= (ev_q & ~ev_clr) | ev_set;
    end

    always_comb begin
        case (bus_addr)
            A_MODE:  bus_rdata = BUS_W'(mode_q);
            A_CMP:   bus_rdata = BUS_W'(cmp_q);
            A_CAP:   bus_rdata = BUS_W'(cap_q);
            A_CNT:   bus_rdata = BUS_W'(cnt_q);
            A_EVT:   bus_rdata = BUS_W'(ev_q);
            default: bus_rdata = '0;
        endcase
    end

    assign tmr_out = out_q;
    assign irq     = (ev_q[EV_CMP] & mode_q.ref_ie)
                   | (ev_q[EV_CAP] & (mode_q.cap_sel != EDGE_OFF));

    AST_EV_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ev_q[EV_CMP] && !(bus_wr && bus_addr == A_EVT && bus_wdata[EV_CMP]))
        |=> ev_q[EV_CMP]); // R8
    AST_EV_W1C: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_EVT && bus_wdata[EV_CAP] && !cap_hit)
        |=> !ev_q[EV_CAP]); // R8
    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq |-> (ev_q != '0)); // R9
    AST_CNT_READONLY: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_CNT && !mode_q.run) |=> (cnt_q == '0)); // R10
endmodule

// File: tb/gp_timer_tb.sv
`timescale 1ns/100ps
module gp_timer_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [2:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        ext_clk;
    logic        cap_in;
    logic        tmr_out;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_mode, m_cmp, m_cap, m_cnt, m_ev, m_d, m_p, m_out;
    int e1, e2, e3, c1, c2, c3;

    always #2 clk = ~clk;

    gp_timer u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk(ext_clk),
        .cap_in(cap_in), .tmr_out(tmr_out), .irq(irq)
    );

    task automatic chk(int got, int exp, string tag);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    always @(posedge clk) begin : model
        int ps, ce, om, frr, cs, en, src, tick, match, rise, fall, hit, clr, set;
        if (rst) begin
            m_mode = 0; m_cmp = 0; m_cap = 0; m_cnt = 0; m_ev = 0;
            m_d = 0; m_p = 0; m_out = 1;
            e1 = 0; e2 = 0; e3 = 0; c1 = 0; c2 = 0; c3 = 0;
        end else begin
            ps  = (m_mode >> 8) & 255;
            ce  = (m_mode >> 6) & 3;
            om  = (m_mode >> 5) & 1;
            frr = (m_mode >> 3) & 1;
            cs  = (m_mode >> 1) & 3;
            en  = m_mode & 1;
            if (!en)          src = 0;
            else if (cs == 1) src = 1;
            else if (cs == 2) src = (m_d == 15);
            else if (cs == 3) src = (e2 == 1 && e3 == 0);
            else              src = 0;
            tick  = src && (m_p == ps);
            match = tick && (m_cnt == m_cmp);
            rise  = (c2 == 1 && c3 == 0);
            fall  = (c2 == 0 && c3 == 1);
            hit   = (ce == 1 && rise) || (ce == 2 && fall) || (ce == 3 && (rise || fall));
            set   = (hit ? 1 : 0) | (match ? 2 : 0);
            clr   = (bus_wr && bus_addr == 4) ? (bus_wdata & 3) : 0;
            if (hit) m_cap = m_cnt;
            m_ev = ((m_ev & ~clr) | set) & 3;
            if (!en) begin
                m_cnt = 0; m_p = 0; m_d = 0; m_out = 1;
            end else begin
                m_d = (m_d + 1) % 16;
                if (src) m_p = (m_p == ps) ? 0 : (m_p + 1) % 256;
                if (match) begin
                    m_cnt = frr ? 0 : (m_cnt + 1) % 65536;
                    m_out = om ? 1 - m_out : 0;
                end else if (tick) begin
                    m_cnt = (m_cnt + 1) % 65536;
                    if (!om) m_out = 1;
                end
            end
            e3 = e2; e2 = e1; e1 = ext_clk;
            c3 = c2; c2 = c1; c1 = cap_in;
            if (bus_wr && bus_addr == 0) m_mode = bus_wdata;
            if (bus_wr && bus_addr == 1) m_cmp  = bus_wdata;
        end
    end

    function automatic int exp_rd(int a);
        case (a)
            0: return m_mode;
            1: return m_cmp;
            2: return m_cap;
            3: return m_cnt;
            4: return m_ev;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_irq();
        return ((((m_ev >> 1) & 1) & ((m_mode >> 4) & 1)) == 1) ||
               ((m_ev & 1) == 1 && ((m_mode >> 6) & 3) != 0);
    endfunction

    always @(negedge clk) begin
        string tag;
        if (!rst && !done) begin
            case (bus_addr)
                3'd0: tag = "R2 mode readback";
                3'd1: tag = "R5 compare readback";
                3'd2: tag = "R7 capture value";
                3'd3: tag = "R5 count";
                3'd4: tag = "R8 event flags";
                default: tag = "R10 unused address";
            endcase
            chk(bus_rdata, exp_rd(bus_addr), tag);
            chk(tmr_out, m_out, "R6 output pin");
            chk(irq, exp_irq(), "R9 interrupt");
        end
    end

    task automatic step(int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(int a, int d);
        bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(d);
        step(1);
        bus_wr = 1'b0; bus_addr = 3'd3; bus_wdata = 16'h0;
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired (all requirements)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = 3'd3; bus_wdata = 16'h0;
        ext_clk = 1'b0; cap_in = 1'b0;
        step(3);
        rst = 1'b0;
        #0.5;
        chk(bus_rdata, 0, "R1 count after reset");
        chk(tmr_out, 1, "R1 output after reset");
        chk(irq, 0, "R1 irq after reset");
        step(1);

        // R10: read-only registers ignore writes
        wr(3, 16'h1234);
        wr(2, 16'h0055);
        bus_addr = 3'd2; #0.5;
        chk(bus_rdata, 0, "R10 capture ignores write");
        bus_addr = 3'd3; #0.5;
        chk(bus_rdata, 0, "R10 count ignores write");
        step(1);

        // R2: run bit clear holds everything idle
        wr(1, 5);
        wr(0, 16'h0002);
        step(10);
        chk(bus_rdata, 0, "R2 idle count");
        chk(tmr_out, 1, "R2 idle output");

        // R5/R6: restart at 5, pulse output, compare interrupt enabled
        wr(0, 16'h001B);
        step(30);
        wr(4, 2);
        step(5);

        // R5/R6: free-run past compare, toggle output, through the 16-bit wrap
        wr(1, 3);
        wr(0, 16'h0033);
        step(66000);
        wr(4, 3);

        // R4: prescale 3 on system clock
        wr(0, 0);
        wr(1, 16'hFFFF);
        wr(0, 16'h0303);
        step(40);
        chk(bus_rdata, 10, "R4 prescale by 4 after 40 clocks");
        step(20);

        // R3: divide-by-16 with prescale 1, restart at 4
        wr(0, 0);
        wr(1, 4);
        wr(0, 16'h010D);
        step(96);
        chk(bus_rdata, 3, "R3 divide-by-16 after 96 clocks");
        step(300);

        // R3: stopped source
        wr(0, 0);
        wr(0, 16'h0001);
        step(20);
        chk(bus_rdata, 0, "R3 stopped source");

        // R3: external edges, irregular spacing, restart at 7
        wr(0, 0);
        wr(1, 7);
        wr(0, 16'h001F);
        for (int i = 0; i < 60; i++) begin
            ext_clk = ~ext_clk;
            step(1 + (i % 4));
        end
        step(5);
        wr(4, 3);

        // R7/R8: capture on each edge setting
        wr(1, 16'hFFFF);
        for (int s = 0; s < 4; s++) begin
            wr(0, ((3 - s) << 6) | 16'h0003);
            for (int i = 0; i < 12; i++) begin
                cap_in = ~cap_in;
                step(3 + (i * 5) % 7);
            end
            if (s == 3) begin
                bus_addr = 3'd4; #0.5;
                chk(bus_rdata & 1, 0, "R7 capture disabled leaves event clear");
                bus_addr = 3'd3;
                step(1);
            end
            bus_addr = 3'd2;
            step(2);
            bus_addr = 3'd3;
            wr(4, 1);
            bus_addr = 3'd4;
            step(2);
            bus_addr = 3'd3;
        end

        // R10: sweep all addresses
        for (int a = 0; a < 8; a++) begin
            bus_addr = 3'(a);
            step(1);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule